// File: doc/BRIEF.md
# Three-Stage Integer Pipeline with ALU Result Bypass

This block is a small in-order integer core that overlaps instructions across three stages: fetch, then a combined decode / register-read / ALU stage that also forms load and store addresses, then a final stage that either writes the destination register or moves data to or from data memory. With no conflicts it retires one instruction every clock. The program counter steps by one word per clock from address 0 after reset, and branches are not part of the block.

An instruction that consumes the result of the ALU instruction directly ahead of it does not wait: a multiplexer in front of each ALU operand picks the result held in the final stage instead of the stale register file value. Load data is never forwarded and there is no hardware interlock. Software must leave the slot after a load free of any use of the loaded register. If it does not, that instruction sees the register's previous contents.

The core has a combinational-read instruction memory port, a data memory port with a write strobe and a combinational read, and a port that shows each register file write as it happens. Register 0 always reads as zero.

Top module: `pipe3_core`

## Requirements
- R1: While reset is low and for the first two clocks after it rises, `imem_addr_o` starts at 0, and neither `rf_we_o` nor `dmem_we_o` is asserted.
- R2: In the cycle after the Nth rising clock edge since reset was released, `imem_addr_o` equals N (modulo 2^IAW), so one instruction is fetched per clock with no stalls.
- R3: Instruction word fields are: opcode in bits 15:12, destination in 11:9, first source in 8:6, second source in 5:3. Opcodes 1, 2, 3, 4 and 5 mean add, subtract (first minus second), AND, OR and XOR. The instruction fetched at address k puts its result on the write port (`rf_we_o`, `rf_waddr_o`, `rf_wdata_o`) in the cycle after the (k+2)th edge.
- R4: Register 0 reads as zero as an operand. An instruction whose destination is register 0 leaves `rf_we_o` low.
- R5: An instruction that reads a register written by the ALU instruction directly before it receives the new value, for either operand and for the base and data of a store.
- R6: Opcode 8 is a load. The destination is in bits 11:9, the base register in 8:6, and a 6-bit signed offset in 5:0. In its final cycle `dmem_addr_o` is base + offset (low DAW bits), and the destination is written with `dmem_rdata_i`.
- R7: Opcode 9 is a store. The data register is in bits 11:9, the base in 8:6, and the offset in 5:0. In its final cycle `dmem_we_o` is high with that address and `dmem_wdata_o` holds the data register, and `rf_we_o` stays low.
- R8: The instruction right after a load that reads the loaded register gets that register's value from before the load. The instruction after that one gets the loaded value.
- R9: Opcode 0 and every opcode not listed above write neither a register nor memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | IAW | Fetch address (word index) |
| imem_data_i | input | 16 | Instruction word at `imem_addr_o`, same cycle |
| dmem_addr_o | output | DAW | Data memory word address |
| dmem_we_o | output | 1 | Data memory write strobe |
| dmem_wdata_o | output | XLEN | Store data |
| dmem_rdata_i | input | XLEN | Read data at `dmem_addr_o`, same cycle |
| rf_we_o | output | 1 | Register file write this cycle |
| rf_waddr_o | output | 3 | Register being written |
| rf_wdata_o | output | XLEN | Value being written |

## Verification
On every cycle the assertions check the single-step program counter, that an ALU result in decode reaches the write port one clock later, that the bypass selects the final-stage result on an ALU match and the register file value on a load match, that register 0 is never written, and that a store never coincides with a register write. Only the bench's programs can show that whole instruction sequences compute the right values. That covers stale reads after a load that breaks the delay-slot rule, a store followed by a load of the same word, and dense random mixes of dependent ALU, load, store and unassigned opcodes, all compared against a sequential model of the instruction set.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;
  localparam int ILEN   = 16;
  localparam int RIDX_W = 3;
  localparam int NREG   = 1 << RIDX_W;
  localparam int IMM_W  = 6;

  localparam logic [3:0] OPC_NOP = 4'h0;
  localparam logic [3:0] OPC_ADD = 4'h1;
  localparam logic [3:0] OPC_SUB = 4'h2;
  localparam logic [3:0] OPC_AND = 4'h3;
  localparam logic [3:0] OPC_OR  = 4'h4;
  localparam logic [3:0] OPC_XOR = 4'h5;
  localparam logic [3:0] OPC_LD  = 4'h8;
  localparam logic [3:0] OPC_ST  = 4'h9;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR} alu_op_e;
  typedef logic [RIDX_W-1:0] ridx_t;

  typedef struct packed {
    logic    wr;
    logic    ld;
    logic    st;
    logic    use_imm;
    alu_op_e op;
    ridx_t   rd;
    ridx_t   rs1;
    ridx_t   rs2;
  } dec_t;

  typedef struct packed {
    logic  wr;
    logic  ld;
    logic  st;
    ridx_t rd;
  } ex_t;

  function automatic dec_t decode(input logic [ILEN-1:0] ir);
    dec_t d;
    d.wr      = 1'b0;
    d.ld      = 1'b0;
    d.st      = 1'b0;
    d.use_imm = 1'b0;
    d.op      = ALU_ADD;
    d.rd      = ir[11:9];
    d.rs1     = ir[8:6];
    d.rs2     = ir[5:3];
    case (ir[15:12])
      OPC_ADD: begin d.op = ALU_ADD; d.wr = (d.rd != '0); end
      OPC_SUB: begin d.op = ALU_SUB; d.wr = (d.rd != '0); end
      OPC_AND: begin d.op = ALU_AND; d.wr = (d.rd != '0); end
      OPC_OR:  begin d.op = ALU_OR;  d.wr = (d.rd != '0); end
      OPC_XOR: begin d.op = ALU_XOR; d.wr = (d.rd != '0); end
      OPC_LD:  begin d.ld = 1'b1; d.use_imm = 1'b1; d.wr = (d.rd != '0); end
      OPC_ST:  begin d.st = 1'b1; d.use_imm = 1'b1; d.rs2 = ir[11:9]; end
      default: ;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/pipe3_regfile.sv
module pipe3_regfile
  import pipe3_pkg::*;
#(
  parameter int XLEN = 16,
  parameter int NRD  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  ridx_t           waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  ridx_t           raddr_i [NRD],
  output logic [XLEN-1:0] rdata_o [NRD]
);
  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  // write lands at the edge; a same-cycle reader sees the old value
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = (raddr_i[g] == '0) ? '0 : regs_q[raddr_i[g]];
  end

  a_r4_no_zero_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (waddr_i != '0));
endmodule

// File: rtl/pipe3_alu.sv
module pipe3_alu
  import pipe3_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o
);
  always_comb begin
    case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_XOR: y_o = a_i ^ b_i;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/pipe3_fwd.sv
module pipe3_fwd
  import pipe3_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  ridx_t           src_i,
  input  logic [XLEN-1:0] rf_val_i,
  input  logic            e_wr_i,
  input  logic            e_ld_i,
  input  ridx_t           e_rd_i,
  input  logic [XLEN-1:0] e_res_i,
  output logic [XLEN-1:0] val_o
);
  logic hit;
  // load data is deliberately not a bypass source
  assign hit   = e_wr_i && !e_ld_i && (e_rd_i == src_i);
  assign val_o = hit ? e_res_i : rf_val_i;
endmodule

// File: rtl/pipe3_core.sv
module pipe3_core
  import pipe3_pkg::*;
#(
  parameter int XLEN = 16,
  parameter int IAW  = 8,
  parameter int DAW  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [IAW-1:0]    imem_addr_o,
  input  logic [ILEN-1:0]   imem_data_i,
  output logic [DAW-1:0]    dmem_addr_o,
  output logic              dmem_we_o,
  output logic [XLEN-1:0]   dmem_wdata_o,
  input  logic [XLEN-1:0]   dmem_rdata_i,
  output logic              rf_we_o,
  output logic [RIDX_W-1:0] rf_waddr_o,
  output logic [XLEN-1:0]   rf_wdata_o
);
  localparam int NOPD = 2;

  // stage I
  logic [IAW-1:0]  pc_q;
  logic [ILEN-1:0] ir_q;
  logic            a_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      ir_q    <= '0;
      a_vld_q <= 1'b0;
    end else begin
      pc_q    <= pc_q + 1'b1;
      ir_q    <= imem_data_i;
      a_vld_q <= 1'b1;
    end
  end
  assign imem_addr_o = pc_q;

  // stage A
  dec_t            dec;
  ridx_t           src_idx [NOPD];
  logic [XLEN-1:0] rf_val  [NOPD];
  logic [XLEN-1:0] op_v    [NOPD];
  logic [XLEN-1:0] imm_x, alu_b, alu_y;

  ex_t             e_q;
  logic [XLEN-1:0] e_res_q, e_sd_q;

  always_comb dec = a_vld_q ? decode(ir_q) : '0;
  assign src_idx[0] = dec.rs1;
  assign src_idx[1] = dec.rs2;

  pipe3_regfile #(.XLEN(XLEN), .NRD(NOPD)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we_o),
    .waddr_i (rf_waddr_o),
    .wdata_i (rf_wdata_o),
    .raddr_i (src_idx),
    .rdata_o (rf_val)
  );

  for (genvar g = 0; g < NOPD; g++) begin : g_fwd
    pipe3_fwd #(.XLEN(XLEN)) u_fwd (
      .src_i    (src_idx[g]),
      .rf_val_i (rf_val[g]),
      .e_wr_i   (e_q.wr),
      .e_ld_i   (e_q.ld),
      .e_rd_i   (e_q.rd),
      .e_res_i  (e_res_q),
      .val_o    (op_v[g])
    );
  end

  assign imm_x = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign alu_b = dec.use_imm ? imm_x : op_v[1];

  pipe3_alu #(.XLEN(XLEN)) u_alu (
    .op_i (dec.op),
    .a_i  (op_v[0]),
    .b_i  (alu_b),
    .y_o  (alu_y)
  );

  // stage E
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_q     <= '0;
      e_res_q <= '0;
      e_sd_q  <= '0;
    end else begin
      e_q     <= '{wr: dec.wr, ld: dec.ld, st: dec.st, rd: dec.rd};
      e_res_q <= alu_y;
      e_sd_q  <= op_v[1];
    end
  end

  assign dmem_addr_o  = e_res_q[DAW-1:0];
  assign dmem_we_o    = e_q.st;
  assign dmem_wdata_o = e_sd_q;
  assign rf_we_o      = e_q.wr;
  assign rf_waddr_o   = e_q.rd;
  assign rf_wdata_o   = e_q.ld ? dmem_rdata_i : e_res_q;

  a_r1_quiet_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_vld_q |-> (!rf_we_o && !dmem_we_o));

  a_r2_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_vld_q |-> (pc_q == $past(pc_q) + IAW'(1)));

  a_r3_alu_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.wr && !dec.ld) |=> (rf_we_o && rf_waddr_o == $past(dec.rd)
                             && rf_wdata_o == $past(alu_y)));

  a_r5_alu_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_q.wr && !e_q.ld && e_q.rd == dec.rs1) |-> (op_v[0] == e_res_q));

  a_r8_no_load_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_q.ld && e_q.rd == dec.rs1) |-> (op_v[0] == rf_val[0]));

  a_r7_store_no_rf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> !rf_we_o);
endmodule

// File: tb/sim_pipe3_core.sv
`timescale 1ns/1ps
module sim_pipe3_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  imem_addr;
  logic [15:0] imem_data;
  logic [7:0]  dmem_addr;
  logic        dmem_we;
  logic [15:0] dmem_wdata;
  logic [15:0] dmem_rdata;
  logic        rf_we;
  logic [2:0]  rf_waddr;
  logic [15:0] rf_wdata;

  always #5 clk = ~clk;

  pipe3_core u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .dmem_addr_o(dmem_addr), .dmem_we_o(dmem_we),
    .dmem_wdata_o(dmem_wdata), .dmem_rdata_i(dmem_rdata),
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata)
  );

  logic [15:0] imem [256];
  logic [15:0] dmem [256];
  logic [15:0] mmem [256];
  int          seed = 0;

  function automatic logic [15:0] dm_init(int i, int s);
    return 16'((i * 849) + (s * 467)) ^ 16'h5a5a;
  endfunction

  assign imem_data  = imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) dmem[i] <= dm_init(i, seed);
    end else if (dmem_we) begin
      dmem[dmem_addr] <= dmem_wdata;
    end
  end

  int total = 0;
  int bad   = 0;

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // expected per-instruction effects
  bit          x_we [256];
  logic [2:0]  x_wa [256];
  logic [15:0] x_wd [256];
  bit          x_st [256];
  bit          x_mem[256];
  logic [7:0]  x_ma [256];
  logic [15:0] x_sd [256];
  string       x_tag[256];

  function automatic logic [15:0] enc_r(int op, int rd, int a, int b);
    return {op[3:0], rd[2:0], a[2:0], b[2:0], 3'b000};
  endfunction
  function automatic logic [15:0] enc_i(int op, int r, int base, int imm);
    return {op[3:0], r[2:0], base[2:0], imm[5:0]};
  endfunction

  task automatic build_model();
    logic [15:0] rf [8];
    bit          pl = 0;
    logic [2:0]  prd = 0;
    logic [15:0] pold = 0;
    logic [2:0]  palu = 0;
    for (int i = 0; i < 8; i++) rf[i] = '0;
    for (int i = 0; i < 256; i++) mmem[i] = dm_init(i, seed);
    for (int k = 0; k < 256; k++) begin
      logic [15:0] ir, va, vb, vd, imm, res;
      logic [3:0]  op;
      logic [2:0]  rd, a, b;
      logic [7:0]  ad;
      bit          viol, npl;
      ir = imem[k]; op = ir[15:12]; rd = ir[11:9]; a = ir[8:6]; b = ir[5:3];
      va = (a == 0) ? 16'h0 : ((pl && prd == a) ? pold : rf[a]);
      vb = (b == 0) ? 16'h0 : ((pl && prd == b) ? pold : rf[b]);
      vd = (rd == 0) ? 16'h0 : ((pl && prd == rd) ? pold : rf[rd]);
      imm = {{10{ir[5]}}, ir[5:0]};
      x_we[k] = 0; x_wa[k] = 0; x_wd[k] = 0; x_st[k] = 0; x_mem[k] = 0;
      x_ma[k] = 0; x_sd[k] = 0; x_tag[k] = "R9";
      npl = 0;
      case (op)
        4'h1, 4'h2, 4'h3, 4'h4, 4'h5: begin
          viol = pl && prd != 0 && (prd == a || prd == b);
          case (op)
            4'h1: res = va + vb;
            4'h2: res = va - vb;
            4'h3: res = va & vb;
            4'h4: res = va | vb;
            default: res = va ^ vb;
          endcase
          x_we[k] = (rd != 0); x_wa[k] = rd; x_wd[k] = res;
          if (viol) x_tag[k] = "R8";
          else if (rd == 0 || a == 0 || b == 0) x_tag[k] = "R4";
          else if (palu != 0 && (palu == a || palu == b)) x_tag[k] = "R5";
          else x_tag[k] = "R3";
          if (rd != 0) rf[rd] = res;
        end
        4'h8: begin
          viol = pl && prd != 0 && prd == a;
          ad = 8'(va + imm);
          x_mem[k] = 1; x_ma[k] = ad;
          x_we[k] = (rd != 0); x_wa[k] = rd; x_wd[k] = mmem[ad];
          x_tag[k] = viol ? "R8" : "R6";
          npl = (rd != 0);
          pold = rf[rd];
          if (rd != 0) rf[rd] = mmem[ad];
        end
        4'h9: begin
          viol = pl && prd != 0 && (prd == a || prd == rd);
          ad = 8'(va + imm);
          x_mem[k] = 1; x_st[k] = 1; x_ma[k] = ad; x_sd[k] = vd;
          x_tag[k] = viol ? "R8" : "R7";
          mmem[ad] = vd;
        end
        default: ;
      endcase
      palu = (op >= 4'h1 && op <= 4'h5) ? rd : 3'd0;
      pl = npl; prd = rd;
    end
  endtask

  bit active = 0;
  int pe = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) pe <= 0;
    else        pe <= pe + 1;
  end

  always @(negedge clk) begin
    if (active) begin
      int k;
      k = pe - 2;
      chk(imem_addr == 8'(pe), "R2 pc", {8'h0, imem_addr}, 16'(pe[7:0]));
      if (k < 0) begin
        chk(!rf_we && !dmem_we, "R1 quiet start", {14'h0, rf_we, dmem_we}, 16'h0);
      end else if (k < 256) begin
        chk(rf_we == x_we[k], {x_tag[k], " we"}, {15'h0, rf_we}, {15'h0, x_we[k]});
        if (x_we[k]) begin
          chk(rf_waddr == x_wa[k], {x_tag[k], " waddr"}, {13'h0, rf_waddr}, {13'h0, x_wa[k]});
          chk(rf_wdata == x_wd[k], {x_tag[k], " wdata"}, rf_wdata, x_wd[k]);
        end
        chk(dmem_we == x_st[k], {x_tag[k], " dmem_we"}, {15'h0, dmem_we}, {15'h0, x_st[k]});
        if (x_mem[k])
          chk(dmem_addr == x_ma[k], {x_tag[k], " daddr"}, {8'h0, dmem_addr}, {8'h0, x_ma[k]});
        if (x_st[k])
          chk(dmem_wdata == x_sd[k], {x_tag[k], " sdata"}, dmem_wdata, x_sd[k]);
      end
    end
  end

  task automatic run_prog(int n);
    build_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(imem_addr == 8'h0, "R1 reset pc", {8'h0, imem_addr}, 16'h0);
    chk(!rf_we && !dmem_we, "R1 reset we", {14'h0, rf_we, dmem_we}, 16'h0);
    @(posedge clk); #2;
    rst_n = 1'b1; active = 1'b1;
    repeat (n + 4) @(posedge clk);
    #2;
    active = 1'b0; rst_n = 1'b0;
  endtask

  task automatic clear_imem();
    for (int i = 0; i < 256; i++) imem[i] = 16'h0;
  endtask

  initial begin
    int lcg;
    int opt [12];
    opt = '{1, 2, 3, 4, 5, 8, 9, 0, 7, 1, 2, 8};

    // P1: ALU chains, bypass on each operand, register 0, unassigned opcode
    seed = 1; clear_imem();
    imem[0]  = enc_i(8, 1, 0, 0);
    imem[1]  = enc_i(8, 2, 0, 1);
    imem[2]  = enc_r(0, 0, 0, 0);
    imem[3]  = enc_r(1, 3, 1, 2);   // R3
    imem[4]  = enc_r(2, 4, 3, 1);   // R5 first operand
    imem[5]  = enc_r(5, 5, 2, 4);   // R5 second operand
    imem[6]  = enc_r(3, 6, 5, 5);   // R5 both
    imem[7]  = enc_r(4, 0, 6, 1);   // R4 no write
    imem[8]  = enc_r(1, 7, 0, 6);   // R4 zero operand
    imem[9]  = enc_r(7, 3, 1, 2);   // R9 unassigned
    imem[10] = enc_r(2, 3, 3, 7);
    imem[11] = enc_r(4, 2, 3, 3);
    run_prog(14);

    // P2: loads, stores, delay slot honoured and violated
    seed = 2; clear_imem();
    imem[0]  = enc_i(8, 1, 0, 2);
    imem[1]  = enc_r(1, 2, 1, 1);   // R8 stale (zero)
    imem[2]  = enc_r(1, 3, 1, 1);   // loaded value
    imem[3]  = enc_i(9, 3, 0, 5);   // R7 store, data bypassed
    imem[4]  = enc_i(8, 4, 0, 5);   // R6 load same word
    imem[5]  = enc_r(0, 0, 0, 0);
    imem[6]  = enc_i(8, 5, 4, 6'h3f);
    imem[7]  = enc_i(8, 1, 0, 9);
    imem[8]  = enc_i(9, 1, 0, 12);  // R8 store of stale data
    imem[9]  = enc_i(9, 1, 1, 1);   // base now loaded
    imem[10] = enc_r(2, 6, 3, 2);
    imem[11] = enc_i(9, 6, 6, 6'h20); // R5 base and data bypassed
    imem[12] = enc_i(8, 7, 6, 6'h20);
    imem[13] = enc_i(8, 7, 7, 0);   // R8 base stale
    imem[14] = enc_r(5, 2, 7, 7);
    imem[15] = enc_i(8, 0, 0, 3);   // load to r0, no write
    imem[16] = enc_r(15, 2, 2, 2);  // R9
    run_prog(19);

    // P3: pseudo-random mixes, two seeds
    for (int s = 0; s < 2; s++) begin
      seed = 3 + s; clear_imem();
      lcg = 32'h1234 + s * 977;
      for (int r = 1; r < 8; r++) imem[r-1] = enc_i(8, r, 0, r);
      for (int k = 7; k < 220; k++) begin
        int op, f1, f2, f3, im;
        lcg = lcg * 1103515245 + 12345; op = opt[((lcg >>> 16) & 32'h7fff) % 12];
        lcg = lcg * 1103515245 + 12345; f1 = (lcg >>> 16) & 7;
        lcg = lcg * 1103515245 + 12345; f2 = (lcg >>> 16) & 7;
        lcg = lcg * 1103515245 + 12345; f3 = (lcg >>> 16) & 7;
        lcg = lcg * 1103515245 + 12345; im = (lcg >>> 16) & 63;
        if (op == 8 || op == 9) imem[k] = enc_i(op, f1, f2, im);
        else                    imem[k] = enc_r(op, f1, f2, f3);
      end
      run_prog(224);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 16'h1, 16'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule